// File: doc/BRIEF.md
# DRAM Command Queue with Refresh Insertion

This block sits between a host command port and a DRAM sequencer. Host commands are written into a small first-in, first-out queue. A refresh scheduler shares that queue and places refresh entries into it on its own timetable. The sequencer drains the queue through a valid/ready handshake. Each entry is tagged as either a host command or a refresh.

The host raises an enable line to offer a command. That command is taken only while the busy line is low. Busy rises when the queue is full. It also rises when a refresh has just fallen due. In that second case busy goes high one cycle before the refresh is written, so the refresh never has to compete with a host write.

Refresh deadlines that could not be met are counted, up to a ceiling. Once the queue has room, the owed refreshes are issued back to back. Only the first refresh of such a run holds busy. Each later one goes in only in a cycle where the host is not writing. A level output reports whether any refresh is owed or still waiting in the queue.

Top module: `refq_top`

## Requirements
- R1: The queue holds up to DEPTH entries and delivers them to the sequencer in strict arrival order. seq_valid is high whenever the queue is non-empty. The head entry is removed on a cycle with seq_valid and seq_ready both high. While it is not removed, it stays stable. seq_is_ref is 1 for a refresh entry and 0 for a host entry. A refresh entry carries an all-zero seq_cmd.
- R2: host_busy is high whenever the queue holds DEPTH entries.
- R3: When a refresh falls due with none already in a run, host_busy goes high on the next cycle. It stays high until that refresh has been written into the queue.
- R4: A host_en presented while host_busy is high is ignored. No command is written, and the queue contents seen by the sequencer are unchanged.
- R5: A refresh that raised host_busy is written no earlier than the second cycle of busy. When a host enable and a new refresh deadline coincide, the refresh is written first and the host command is refused.
- R6: Each REF_INTERVAL cycles one refresh is added to an owed count. The count saturates at OWED_MAX and drops by one for each refresh written into the queue.
- R7: After the first refresh of a run, each remaining owed refresh is written only in a cycle with no accepted host command. With host_en held low and room in the queue, they are written on consecutive cycles.
- R8: refresh_active is high exactly when the owed count is non-zero or a refresh entry is still in the queue.
- R9: The first refresh deadline falls INIT_DELAY cycles after reset is released. Later deadlines follow every REF_INTERVAL cycles.
- R10: In reset, and directly after release, host_busy, seq_valid and refresh_active are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host offers a command this cycle |
| host_cmd | input | CMD_W | Host command payload |
| host_busy | output | 1 | Host must not expect its enable to be taken |
| seq_valid | output | 1 | Queue head is valid |
| seq_ready | input | 1 | Sequencer takes the head entry |
| seq_is_ref | output | 1 | Head entry is a refresh (1) or host command (0) |
| seq_cmd | output | CMD_W | Head entry payload, zero for refresh |
| refresh_active | output | 1 | A refresh is owed or still queued |

## Verification
A host enable and a refresh deadline can land in the same cycle. The refresh insertion can also meet the sequencer popping the head. The bench holds host_en high with the sequencer ready across a deadline. It then confirms that busy covers two cycles, that the refresh reaches the head of the queue, and that the refused command never appears. A behavioural reference model, compared on every clock, covers the other case: owed refreshes waiting behind a full queue while the host keeps writing.

// File: rtl/refq_pkg.sv
`timescale 1ns/1ps
package refq_pkg;
  // Entry tag carried alongside every queued payload
  typedef enum logic {
    KIND_HOST = 1'b0,
    KIND_REF  = 1'b1
  } kind_e;
endpackage

// File: rtl/refq_fifo.sv
`timescale 1ns/1ps
module refq_fifo
  import refq_pkg::*;
#(
  parameter int unsigned CMD_W = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  kind_e            push_kind,
  input  logic [CMD_W-1:0] push_cmd,
  input  logic             pop_req,
  output logic [CW-1:0]    count,
  output logic             empty,
  output kind_e            head_kind,
  output logic [CMD_W-1:0] head_cmd
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [CMD_W-1:0] slot_cmd  [DEPTH];
  kind_e            slot_kind [DEPTH];
  logic [PW-1:0]    wr_ptr, wr_ptr_nx;
  logic [PW-1:0]    rd_ptr, rd_ptr_nx;
  logic [CW-1:0]    cnt_nx;
  logic             pop;

  assign empty = (count == '0);
  assign pop   = pop_req && !empty;

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    cnt_nx    = count;
    if (push) wr_ptr_nx = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    if (pop)  rd_ptr_nx = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    case ({push, pop})
      2'b10:   cnt_nx = count + 1'b1;
      2'b01:   cnt_nx = count - 1'b1;
      default: cnt_nx = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      count  <= cnt_nx;
    end
  end

  // Storage slots: data registers without reset, written under enable
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = push && (wr_ptr == PW'(i));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        slot_cmd[i]  <= push_cmd;
        slot_kind[i] <= push_kind;
      end
    end
  end

  assign head_cmd  = slot_cmd[rd_ptr];
  assign head_kind = slot_kind[rd_ptr];

endmodule

// File: rtl/refq_sched.sv
`timescale 1ns/1ps
module refq_sched #(
  parameter int unsigned REF_INTERVAL = 780,
  parameter int unsigned INIT_DELAY   = 2000,
  parameter int unsigned OWED_MAX     = 8,
  localparam int unsigned SPAN = (REF_INTERVAL > INIT_DELAY) ? REF_INTERVAL : INIT_DELAY,
  localparam int unsigned TW   = $clog2(SPAN + 1),
  localparam int unsigned OW   = $clog2(OWED_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_any,     // a refresh entry is written this cycle
  input  logic          ins_urgent,  // that entry is the first of a run
  output logic          urgent,
  output logic          deferred,
  output logic          armed,
  output logic [OW-1:0] owed
);

  localparam logic [TW-1:0] RELOAD = TW'(REF_INTERVAL - 1);
  localparam logic [TW-1:0] FIRST  = TW'(INIT_DELAY - 1);
  localparam logic [OW:0]   CAP    = (OW + 1)'(OWED_MAX);

  logic [TW-1:0] timer, timer_nx;
  logic [OW-1:0] owed_nx;
  logic [OW:0]   owed_sum;
  logic          tick;
  logic          in_run, in_run_nx;
  logic          armed_nx;

  assign tick     = (timer == '0);
  assign urgent   = (owed != '0) && !in_run;
  assign deferred = (owed != '0) && in_run;

  always_comb begin
    timer_nx = tick ? RELOAD : timer - 1'b1;
    owed_sum = {1'b0, owed} + {{OW{1'b0}}, tick} - {{OW{1'b0}}, ins_any};
    owed_nx  = (owed_sum > CAP) ? CAP[OW-1:0] : owed_sum[OW-1:0];
    if (owed_nx == '0)  in_run_nx = 1'b0;
    else if (ins_any)   in_run_nx = 1'b1;
    else                in_run_nx = in_run;
    armed_nx = urgent && !ins_urgent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer  <= FIRST;
      owed   <= '0;
      in_run <= 1'b0;
      armed  <= 1'b0;
    end else begin
      timer  <= timer_nx;
      owed   <= owed_nx;
      in_run <= in_run_nx;
      armed  <= armed_nx;
    end
  end

endmodule

// File: rtl/refq_arb.sv
`timescale 1ns/1ps
module refq_arb
  import refq_pkg::*;
#(
  parameter int unsigned CMD_W = 32
) (
  input  logic             host_en,
  input  logic [CMD_W-1:0] host_cmd,
  input  logic             urgent,
  input  logic             armed,
  input  logic             deferred,
  input  logic             full,
  output logic             busy,
  output logic             host_acc,
  output logic             urg_ins,
  output logic             ref_ins,
  output logic             push,
  output kind_e            push_kind,
  output logic [CMD_W-1:0] push_cmd
);

  logic def_ins;

  always_comb begin
    busy      = urgent || full;
    host_acc  = host_en && !busy;
    urg_ins   = urgent && armed && !full;
    def_ins   = deferred && !host_acc && !full;
    ref_ins   = urg_ins || def_ins;
    push      = host_acc || ref_ins;
    push_kind = ref_ins ? KIND_REF : KIND_HOST;
    push_cmd  = ref_ins ? '0 : host_cmd;
  end

endmodule

// File: rtl/refq_top.sv
`timescale 1ns/1ps
module refq_top
  import refq_pkg::*;
#(
  parameter int unsigned CMD_W        = 32,
  parameter int unsigned DEPTH        = 4,
  parameter int unsigned REF_INTERVAL = 780,
  parameter int unsigned INIT_DELAY   = 2000,
  parameter int unsigned OWED_MAX     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_en,
  input  logic [CMD_W-1:0] host_cmd,
  output logic             host_busy,
  output logic             seq_valid,
  input  logic             seq_ready,
  output logic             seq_is_ref,
  output logic [CMD_W-1:0] seq_cmd,
  output logic             refresh_active
);

  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned OW = $clog2(OWED_MAX + 1);

  logic [CW-1:0]    q_count;
  logic             q_empty;
  logic             q_full;
  kind_e            head_kind;
  logic             urgent, deferred, armed;
  logic [OW-1:0]    owed;
  logic             host_acc, urg_ins, ref_ins, push;
  kind_e            push_kind;
  logic [CMD_W-1:0] push_cmd;
  logic             head_pop;
  logic [CW-1:0]    refs_q, refs_q_nx;

  assign q_full   = (q_count == CW'(DEPTH));
  assign head_pop = seq_ready && !q_empty;

  refq_sched #(
    .REF_INTERVAL (REF_INTERVAL),
    .INIT_DELAY   (INIT_DELAY),
    .OWED_MAX     (OWED_MAX)
  ) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_any    (ref_ins),
    .ins_urgent (urg_ins),
    .urgent     (urgent),
    .deferred   (deferred),
    .armed      (armed),
    .owed       (owed)
  );

  refq_arb #(.CMD_W(CMD_W)) u_arb (
    .host_en   (host_en),
    .host_cmd  (host_cmd),
    .urgent    (urgent),
    .armed     (armed),
    .deferred  (deferred),
    .full      (q_full),
    .busy      (host_busy),
    .host_acc  (host_acc),
    .urg_ins   (urg_ins),
    .ref_ins   (ref_ins),
    .push      (push),
    .push_kind (push_kind),
    .push_cmd  (push_cmd)
  );

  refq_fifo #(.CMD_W(CMD_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_kind (push_kind),
    .push_cmd  (push_cmd),
    .pop_req   (seq_ready),
    .count     (q_count),
    .empty     (q_empty),
    .head_kind (head_kind),
    .head_cmd  (seq_cmd)
  );

  // Count of refresh entries still waiting in the queue
  always_comb begin
    refs_q_nx = refs_q;
    case ({ref_ins, head_pop && (head_kind == KIND_REF)})
      2'b10:   refs_q_nx = refs_q + 1'b1;
      2'b01:   refs_q_nx = refs_q - 1'b1;
      default: refs_q_nx = refs_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) refs_q <= '0;
    else        refs_q <= refs_q_nx;
  end

  assign seq_valid      = !q_empty;
  assign seq_is_ref     = (head_kind == KIND_REF);
  assign refresh_active = (owed != '0) || (refs_q != '0);

endmodule

// File: rtl/refq_checker.sv
`timescale 1ns/1ps
module refq_checker #(
  parameter int unsigned CMD_W    = 32,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned OWED_MAX = 8,
  parameter int unsigned CW       = 3,
  parameter int unsigned OW       = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_busy,
  input logic             seq_valid,
  input logic             seq_ready,
  input logic             seq_is_ref,
  input logic [CMD_W-1:0] seq_cmd,
  input logic             refresh_active,
  input logic [CW-1:0]    q_count,
  input logic [OW-1:0]    owed,
  input logic             host_acc,
  input logic             ref_ins,
  input logic             urg_ins
);

  assert_full_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == CW'(DEPTH)) |-> host_busy);

  assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_busy |-> !host_acc);

  assert_single_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_acc |-> !ref_ins);

  assert_head_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_valid && !seq_ready) |=> (seq_valid && $stable(seq_cmd) && $stable(seq_is_ref)));

  assert_ref_payload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_valid && seq_is_ref) |-> (seq_cmd == '0));

  assert_busy_leads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    urg_ins |-> $past(host_busy));

  assert_owed_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(OWED_MAX));

  assert_active_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (owed != '0) |-> refresh_active);

endmodule

bind refq_top refq_checker #(
  .CMD_W    (CMD_W),
  .DEPTH    (DEPTH),
  .OWED_MAX (OWED_MAX),
  .CW       (CW),
  .OW       (OW)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_busy      (host_busy),
  .seq_valid      (seq_valid),
  .seq_ready      (seq_ready),
  .seq_is_ref     (seq_is_ref),
  .seq_cmd        (seq_cmd),
  .refresh_active (refresh_active),
  .q_count        (q_count),
  .owed           (owed),
  .host_acc       (host_acc),
  .ref_ins        (ref_ins),
  .urg_ins        (urg_ins)
);

// File: tb/refq_top_bench.sv
`timescale 1ns/1ps
module refq_top_bench;

  localparam int CMD_W = 8;
  localparam int DEPTH = 4;
  localparam int IVL   = 40;
  localparam int INIT  = 30;
  localparam int OMAX  = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             host_en;
  logic [CMD_W-1:0] host_cmd;
  logic             host_busy;
  logic             seq_valid;
  logic             seq_ready;
  logic             seq_is_ref;
  logic [CMD_W-1:0] seq_cmd;
  logic             refresh_active;

  always #10 clk = ~clk;

  refq_top #(
    .CMD_W(CMD_W), .DEPTH(DEPTH), .REF_INTERVAL(IVL),
    .INIT_DELAY(INIT), .OWED_MAX(OMAX)
  ) u_refq_top (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_cmd(host_cmd),
    .host_busy(host_busy), .seq_valid(seq_valid), .seq_ready(seq_ready),
    .seq_is_ref(seq_is_ref), .seq_cmd(seq_cmd), .refresh_active(refresh_active)
  );

  int n_checks = 0;
  int n_err    = 0;
  int edges    = 0;
  bit done     = 1'b0;

  // Behavioural reference state
  int m_timer, m_owed;
  bit m_run, m_arm;
  int mq_cmd[$];
  bit mq_ref[$];

  // Pops observed at the ports in the current window
  int w_refs;
  int w_host[$];

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, edges);
    end
  endtask

  function automatic bit m_busy();
    return ((m_owed > 0) && !m_run) || (mq_cmd.size() == DEPTH);
  endfunction

  function automatic bit m_active();
    bit any = 1'b0;
    foreach (mq_ref[i]) any |= mq_ref[i];
    return (m_owed > 0) || any;
  endfunction

  task automatic compare();
    chk("R3 busy", host_busy, m_busy());
    chk("R1 valid", seq_valid, mq_cmd.size() > 0);
    if (mq_cmd.size() > 0) begin
      chk("R7 head tag", seq_is_ref, mq_ref[0]);
      chk("R1 head payload", seq_cmd, mq_cmd[0]);
    end
    chk("R8 refresh_active", refresh_active, m_active());
  endtask

  task automatic step(input bit en, input logic [CMD_W-1:0] cmd, input bit rdy);
    bit tick, urg, busy, hacc, uins, dins, pop;
    int owed_n;
    host_en   = en;
    host_cmd  = cmd;
    seq_ready = rdy;
    if (seq_valid && rdy) begin
      if (seq_is_ref) w_refs++;
      else            w_host.push_back(int'(seq_cmd));
    end
    tick = (m_timer == 0);
    urg  = (m_owed > 0) && !m_run;
    busy = urg || (mq_cmd.size() == DEPTH);
    hacc = en && !busy;
    uins = urg && m_arm && (mq_cmd.size() < DEPTH);
    dins = (m_owed > 0) && m_run && !hacc && (mq_cmd.size() < DEPTH);
    pop  = (mq_cmd.size() > 0) && rdy;
    @(posedge clk);
    edges++;
    if (pop) begin
      void'(mq_cmd.pop_front());
      void'(mq_ref.pop_front());
    end
    if (hacc) begin mq_cmd.push_back(int'(cmd)); mq_ref.push_back(1'b0); end
    if (uins || dins) begin mq_cmd.push_back(0); mq_ref.push_back(1'b1); end
    owed_n = m_owed + (tick ? 1 : 0) - ((uins || dins) ? 1 : 0);
    if (owed_n > OMAX) owed_n = OMAX;
    if (owed_n == 0)        m_run = 1'b0;
    else if (uins || dins)  m_run = 1'b1;
    m_arm   = urg && !uins;
    m_timer = tick ? IVL - 1 : m_timer - 1;
    m_owed  = owed_n;
    @(negedge clk);
    compare();
  endtask

  task automatic clear_window();
    w_refs = 0;
    w_host.delete();
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_en = 1'b0; host_cmd = '0; seq_ready = 1'b0;
    m_timer = INIT - 1; m_owed = 0; m_run = 1'b0; m_arm = 1'b0;
    clear_window();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    chk("R10 busy after reset", host_busy, 0);
    chk("R10 valid after reset", seq_valid, 0);
    chk("R10 active after reset", refresh_active, 0);

    // R9: first deadline after INIT cycles
    repeat (INIT - 1) step(1'b0, '0, 1'b1);
    chk("R9 not yet due", host_busy, 0);
    step(1'b0, '0, 1'b1);
    chk("R9 busy at first deadline", host_busy, 1);
    chk("R9 active at first deadline", refresh_active, 1);
    // R5: refresh written only on the second busy cycle
    step(1'b0, '0, 1'b1);
    chk("R5 no write on first busy cycle", seq_valid, 0);
    chk("R5 busy held", host_busy, 1);
    step(1'b0, '0, 1'b1);
    chk("R5 refresh at head", seq_valid && seq_is_ref, 1);
    chk("R3 busy released after write", host_busy, 0);

    // R5: host enable held across the deadline at edge 70
    while (edges < 69) step(1'b1, CMD_W'(edges), 1'b1);
    step(1'b1, 8'h45, 1'b1);
    chk("R3 busy at collision", host_busy, 1);
    step(1'b1, 8'h46, 1'b1);
    chk("R5 busy holds second cycle", host_busy, 1);
    step(1'b1, 8'h47, 1'b1);
    chk("R5 refresh wins collision", seq_valid && seq_is_ref, 1);
    chk("R5 busy drops after write", host_busy, 0);
    while (edges < 85) step(1'b0, '0, 1'b1);

    // R2, R4, R6: fill, hold ignored enables, saturate the owed count
    step(1'b1, 8'hA1, 1'b0);
    step(1'b1, 8'hA2, 1'b0);
    step(1'b1, 8'hA3, 1'b0);
    step(1'b1, 8'hA4, 1'b0);
    chk("R2 busy when full", host_busy, 1);
    while (edges < 231) step(1'b1, 8'hEE, 1'b0);
    chk("R6 active while owed", refresh_active, 1);
    clear_window();
    repeat (14) step(1'b0, '0, 1'b1);
    chk("R4 host entries drained", w_host.size(), 4);
    for (int i = 0; i < 4 && i < w_host.size(); i++)
      chk("R4 only accepted commands in order", w_host[i], 'hA1 + i);
    chk("R6 saturated refresh count", w_refs, OMAX);
    chk("R8 idle after run", refresh_active, 0);

    // R7: deferred refreshes yield to host writes
    step(1'b1, 8'hB1, 1'b0);
    step(1'b1, 8'hB2, 1'b0);
    step(1'b1, 8'hB3, 1'b0);
    step(1'b1, 8'hB4, 1'b0);
    while (edges < 351) step(1'b0, '0, 1'b0);
    clear_window();
    for (int i = 0; i < 12; i++) step(1'b1, CMD_W'(8'hC0 + i), 1'b1);
    chk("R7 only first refresh while host writes", w_refs, 1);
    chk("R7 owed still pending", refresh_active, 1);
    clear_window();
    repeat (8) step(1'b0, '0, 1'b1);
    chk("R7 remaining refreshes issued", w_refs, 2);
    chk("R7 run finished", refresh_active, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule